// File: doc/BRIEF.md
# Multi-Port GPIO Controller with Edge Interrupts

This block is a register-mapped general-purpose I/O controller. It groups its pins into ports of eight. Each port owns a bank of 32-bit registers that sits at a fixed 0x30-byte stride. Through that bank a port's output levels, per-pin drive style, pull-up, interrupt edge, interrupt enable and test force are set. Software reads back the synchronized pin levels and the sticky event flags from the same bank.

Each pin's input passes through a synchronizer before a single selectable edge is detected. The edge is either rising or falling, never both. A detected edge latches a sticky event flag. Each port raises one interrupt line while any flag whose enable bit is set is pending. Flags are cleared by writing ones.

One global word at address 0x00 reports the version and the number of eight-pin cores. Its two low bits drive a clock-request output and a sync-select output. The pads are modelled as separate input, output-value and output-enable bits per pin, plus a pull-up request bit.

Top module: `gpio_multiport_ctrl`

## Requirements
- R1: Port p's bank starts at byte address p*0x30, with word offsets 0x04 input levels (read only), 0x08 output data, 0x0C drive mode, 0x10 pull-up disable, 0x14 event flags, 0x18 interrupt enable, 0x1C force, 0x20 edge select. Any other offset, and any address past the last port, reads 0 and has no effect when written.
- R2: After reset every pin is an undriven input with its pull-up active. Output data, enables, flags, force bits and edge selects are all 0, every interrupt line is low and the clock request is 0.
- R3: The drive mode register holds pin n in bits [2n+1:2n]. The codes are 00 input (not driven), 01 push-pull (drives the output data bit), 10 open-drain (drives low only when the data bit is 0, released otherwise) and 11 open-source (drives high only when the data bit is 1, released otherwise).
- R4: A 1 in a pull-up disable bit leaves that pin floating (pin_pullup low). A 0 requests the pull-up (pin_pullup high).
- R5: The input level register shows each pin after a two-flop synchronizer, so a pin change becomes visible after two clock edges.
- R6: Edge select bit 0 makes only a falling edge set the pin's flag, and bit 1 makes only a rising edge set it. The opposite edge leaves the flag unchanged.
- R7: An event flag is set by its selected edge regardless of the enable bit. A port's interrupt line is high exactly while that port has a flag that is both set and enabled. The flag appears on the third clock edge after the pin change.
- R8: Writing the event register clears each flag whose written bit is 1 and leaves flags whose written bit is 0.
- R9: When a new selected edge and a clearing write hit the same flag on the same clock edge, the flag ends up set.
- R10: While a force bit is 1, the pin's flag is set on every clock, so clearing it has no lasting effect. After the force bit is written 0, the flag can be cleared.
- R11: The global word at 0x00 reads the core count in bits [15:9] and the version in bits [8:2]. Bits 1 and 0 are writable and drive sync_sel and clk_req. Writing 0 drops the clock request, and the read-only fields ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read |
| pin_in | input | NUM_PORTS*PINS_PER_PORT | Pad input levels |
| pin_out | output | NUM_PORTS*PINS_PER_PORT | Pad output levels |
| pin_oe | output | NUM_PORTS*PINS_PER_PORT | Pad output enables |
| pin_pullup | output | NUM_PORTS*PINS_PER_PORT | Pull-up requests |
| irq | output | NUM_PORTS | One interrupt line per port |
| clk_req | output | 1 | Clock-request enable from the global word |
| sync_sel | output | 1 | Sync-select enable from the global word |

## Verification
The bench builds the block with three ports, a two-stage synchronizer, a 9-bit address and version 5. With those values the core-count field reads 3, and the decode is exercised at a non-zero base and at the last port. An address one stride past the last port is also decoded. The interrupt lines of neighbouring ports can be seen staying quiet. The two-stage setting fixes the flag latency at three edges, which lets the bench place an edge and a clearing write on the same clock edge.

// File: rtl/gpio_mp_pkg.sv
package gpio_mp_pkg;

   localparam int PORT_STRIDE_BYTES = 48;

   typedef enum logic [1:0] {
      DRV_INPUT     = 2'b00,
      DRV_PUSHPULL  = 2'b01,
      DRV_OPENDRAIN = 2'b10,
      DRV_OPENSRC   = 2'b11
   } drive_mode_e;

   localparam logic [3:0] IDX_INLVL = 4'd1;
   localparam logic [3:0] IDX_DOUT  = 4'd2;
   localparam logic [3:0] IDX_MODE  = 4'd3;
   localparam logic [3:0] IDX_PULL  = 4'd4;
   localparam logic [3:0] IDX_EVT   = 4'd5;
   localparam logic [3:0] IDX_IEN   = 4'd6;
   localparam logic [3:0] IDX_FORCE = 4'd7;
   localparam logic [3:0] IDX_EDGE  = 4'd8;

   typedef struct packed {
      logic        wr;
      logic        rd;
      logic [3:0]  idx;
      logic [31:0] wdata;
   } reg_req_t;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_level,
   output logic [WIDTH-1:0] rise,
   output logic [WIDTH-1:0] fall
);

   logic [STAGES-1:0][WIDTH-1:0] chain;
   logic [WIDTH-1:0]             prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         prev  <= '0;
      end else begin
         chain <= {chain[STAGES-2:0], async_in};
         prev  <= chain[STAGES-1];
      end
   end

   assign sync_level = chain[STAGES-1];
   assign rise       = chain[STAGES-1] & ~prev;
   assign fall       = ~chain[STAGES-1] & prev;

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
   import gpio_mp_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [2*WIDTH-1:0] mode,
   input  logic [WIDTH-1:0]   dout,
   input  logic [WIDTH-1:0]   pull_dis,
   output logic [WIDTH-1:0]   pin_out,
   output logic [WIDTH-1:0]   pin_oe,
   output logic [WIDTH-1:0]   pin_pullup
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      logic drv_oe;
      logic drv_val;

      always_comb begin
         drv_oe  = 1'b0;
         drv_val = 1'b0;
         unique case (drive_mode_e'(mode[2*i +: 2]))
            DRV_INPUT: begin
               drv_oe  = 1'b0;
               drv_val = 1'b0;
            end
            DRV_PUSHPULL: begin
               drv_oe  = 1'b1;
               drv_val = dout[i];
            end
            DRV_OPENDRAIN: begin
               drv_oe  = ~dout[i];
               drv_val = 1'b0;
            end
            DRV_OPENSRC: begin
               drv_oe  = dout[i];
               drv_val = 1'b1;
            end
         endcase
      end

      assign pin_oe[i]     = drv_oe;
      assign pin_out[i]    = drv_val;
      assign pin_pullup[i] = ~pull_dis[i];
   end

endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
   import gpio_mp_pkg::*;
#(
   parameter int PINS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  reg_req_t        req,
   input  logic [PINS-1:0] sync_level,
   input  logic [PINS-1:0] rise,
   input  logic [PINS-1:0] fall,
   output logic [PINS-1:0]   dout,
   output logic [2*PINS-1:0] mode,
   output logic [PINS-1:0]   pull_dis,
   output logic [PINS-1:0]   evt,
   output logic              irq,
   output logic [31:0]       rdata
);

   logic [PINS-1:0] ien;
   logic [PINS-1:0] force_r;
   logic [PINS-1:0] edge_rise;
   logic [PINS-1:0] clr_mask;
   logic [PINS-1:0] edge_hit;

   if (2*PINS < 32) begin : g_wdata_spare
      logic unused_wdata;
      assign unused_wdata = ^req.wdata[31:2*PINS];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout      <= '0;
         mode      <= '0;
         pull_dis  <= '0;
         ien       <= '0;
         force_r   <= '0;
         edge_rise <= '0;
      end else if (req.wr) begin
         case (req.idx)
            IDX_DOUT:  dout      <= req.wdata[PINS-1:0];
            IDX_MODE:  mode      <= req.wdata[2*PINS-1:0];
            IDX_PULL:  pull_dis  <= req.wdata[PINS-1:0];
            IDX_IEN:   ien       <= req.wdata[PINS-1:0];
            IDX_FORCE: force_r   <= req.wdata[PINS-1:0];
            IDX_EDGE:  edge_rise <= req.wdata[PINS-1:0];
            default: ;
         endcase
      end
   end

   assign clr_mask = (req.wr && (req.idx == IDX_EVT)) ? req.wdata[PINS-1:0] : '0;
   assign edge_hit = (edge_rise & rise) | (~edge_rise & fall);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt <= '0;
      else        evt <= (evt & ~clr_mask) | edge_hit | force_r;
   end

   assign irq = |(evt & ien);

   always_comb begin
      rdata = '0;
      if (req.rd) begin
         case (req.idx)
            IDX_INLVL: rdata[PINS-1:0]   = sync_level;
            IDX_DOUT:  rdata[PINS-1:0]   = dout;
            IDX_MODE:  rdata[2*PINS-1:0] = mode;
            IDX_PULL:  rdata[PINS-1:0]   = pull_dis;
            IDX_EVT:   rdata[PINS-1:0]   = evt;
            IDX_IEN:   rdata[PINS-1:0]   = ien;
            IDX_FORCE: rdata[PINS-1:0]   = force_r;
            IDX_EDGE:  rdata[PINS-1:0]   = edge_rise;
            default:   rdata             = '0;
         endcase
      end
   end

endmodule

// File: rtl/gpio_multiport_ctrl.sv
module gpio_multiport_ctrl
   import gpio_mp_pkg::*;
#(
   parameter int         NUM_PORTS     = 3,
   parameter int         PINS_PER_PORT = 8,
   parameter int         SYNC_STAGES   = 2,
   parameter int         ADDR_W        = 9,
   parameter logic [6:0] VERSION_ID    = 7'd5
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               bus_en,
   input  logic                               bus_we,
   input  logic [ADDR_W-1:0]                  bus_addr,
   input  logic [31:0]                        bus_wdata,
   output logic [31:0]                        bus_rdata,
   input  logic [NUM_PORTS*PINS_PER_PORT-1:0] pin_in,
   output logic [NUM_PORTS*PINS_PER_PORT-1:0] pin_out,
   output logic [NUM_PORTS*PINS_PER_PORT-1:0] pin_oe,
   output logic [NUM_PORTS*PINS_PER_PORT-1:0] pin_pullup,
   output logic [NUM_PORTS-1:0]               irq,
   output logic                               clk_req,
   output logic                               sync_sel
);

   localparam int         NUM_PINS  = NUM_PORTS * PINS_PER_PORT;
   localparam int         SPAN      = NUM_PORTS * PORT_STRIDE_BYTES;
   localparam logic [6:0] CORE_CNT  = 7'((NUM_PINS + 7) / 8);

   if (PINS_PER_PORT < 1 || PINS_PER_PORT > 16) begin : g_bad_pins
      $error("PINS_PER_PORT must lie in 1..16");
   end
   if (NUM_PORTS < 1 || ((NUM_PINS + 7) / 8) > 127) begin : g_bad_ports
      $error("port count out of range for the core-count field");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ADDR_W < 6 || SPAN > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the port banks");
   end

   logic [2*NUM_PINS-1:0]        mode_flat;
   logic [NUM_PINS-1:0]          dout_flat;
   logic [NUM_PINS-1:0]          pulldis_flat;
   logic [NUM_PINS-1:0]          evt_flat;
   logic [NUM_PORTS-1:0][31:0]   port_rdata;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      localparam logic [ADDR_W-1:0] BASE = ADDR_W'(p * PORT_STRIDE_BYTES);

      logic [ADDR_W-1:0]        off;
      logic                     hit;
      reg_req_t                 req;
      logic [PINS_PER_PORT-1:0] lvl, rise, fall;
      logic [PINS_PER_PORT-1:0] dout, pull_dis, evt;
      logic [2*PINS_PER_PORT-1:0] mode;

      assign off = bus_addr - BASE;
      assign hit = (bus_addr >= BASE) && (off < ADDR_W'(PORT_STRIDE_BYTES))
                   && (off[1:0] == 2'b00);

      assign req.wr    = bus_en & bus_we & hit;
      assign req.rd    = bus_en & ~bus_we & hit;
      assign req.idx   = off[5:2];
      assign req.wdata = bus_wdata;

      gpio_in_sync #(.WIDTH(PINS_PER_PORT), .STAGES(SYNC_STAGES)) u_sync (
         .clk       (clk),
         .rst_n     (rst_n),
         .async_in  (pin_in[p*PINS_PER_PORT +: PINS_PER_PORT]),
         .sync_level(lvl),
         .rise      (rise),
         .fall      (fall)
      );

      gpio_port_bank #(.PINS(PINS_PER_PORT)) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .req       (req),
         .sync_level(lvl),
         .rise      (rise),
         .fall      (fall),
         .dout      (dout),
         .mode      (mode),
         .pull_dis  (pull_dis),
         .evt       (evt),
         .irq       (irq[p]),
         .rdata     (port_rdata[p])
      );

      gpio_pad_drive #(.WIDTH(PINS_PER_PORT)) u_pad (
         .mode      (mode),
         .dout      (dout),
         .pull_dis  (pull_dis),
         .pin_out   (pin_out[p*PINS_PER_PORT +: PINS_PER_PORT]),
         .pin_oe    (pin_oe[p*PINS_PER_PORT +: PINS_PER_PORT]),
         .pin_pullup(pin_pullup[p*PINS_PER_PORT +: PINS_PER_PORT])
      );

      assign mode_flat[p*2*PINS_PER_PORT +: 2*PINS_PER_PORT] = mode;
      assign dout_flat[p*PINS_PER_PORT +: PINS_PER_PORT]     = dout;
      assign pulldis_flat[p*PINS_PER_PORT +: PINS_PER_PORT]  = pull_dis;
      assign evt_flat[p*PINS_PER_PORT +: PINS_PER_PORT]      = evt;
   end

   logic       glob_hit;
   logic [1:0] glob_ctl;

   assign glob_hit = (bus_addr == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        glob_ctl <= 2'b00;
      else if (bus_en && bus_we && glob_hit) glob_ctl <= bus_wdata[1:0];
   end

   assign clk_req  = glob_ctl[0];
   assign sync_sel = glob_ctl[1];

   always_comb begin
      bus_rdata = '0;
      for (int p = 0; p < NUM_PORTS; p++) bus_rdata = bus_rdata | port_rdata[p];
      if (bus_en && !bus_we && glob_hit)
         bus_rdata = bus_rdata | {16'h0000, CORE_CNT, VERSION_ID, glob_ctl};
   end

endmodule

// File: rtl/gpio_mp_checker.sv
module gpio_mp_checker #(
   parameter int NUM_PORTS     = 3,
   parameter int PINS_PER_PORT = 8
) (
   input logic                               clk,
   input logic                               rst_n,
   input logic                               bus_en,
   input logic                               bus_we,
   input logic [NUM_PORTS*PINS_PER_PORT-1:0] pin_out,
   input logic [NUM_PORTS*PINS_PER_PORT-1:0] pin_oe,
   input logic [NUM_PORTS*PINS_PER_PORT-1:0] pin_pullup,
   input logic [NUM_PORTS-1:0]               irq,
   input logic                               clk_req,
   input logic [2*NUM_PORTS*PINS_PER_PORT-1:0] mode_flat,
   input logic [NUM_PORTS*PINS_PER_PORT-1:0] dout_flat,
   input logic [NUM_PORTS*PINS_PER_PORT-1:0] pulldis_flat,
   input logic [NUM_PORTS*PINS_PER_PORT-1:0] evt_flat
);

   localparam int NUM_PINS = NUM_PORTS * PINS_PER_PORT;

   assert_reset_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (irq == '0 && pin_oe == '0 && !clk_req));

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin_chk
      assert_input_undriven_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_flat[2*i +: 2] == 2'b00) |-> !pin_oe[i]);
      assert_opendrain_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_flat[2*i +: 2] == 2'b10) |-> (!pin_out[i] && (pin_oe[i] == !dout_flat[i])));
      assert_opensource_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_flat[2*i +: 2] == 2'b11) |-> (pin_out[i] && (pin_oe[i] == dout_flat[i])));
      assert_pullup_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
         pin_pullup[i] == !pulldis_flat[i]);
      assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(evt_flat[i]) |-> $past(bus_en && bus_we));
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_chk
      assert_irq_has_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
         irq[p] |-> (evt_flat[p*PINS_PER_PORT +: PINS_PER_PORT] != '0));
   end

endmodule

bind gpio_multiport_ctrl gpio_mp_checker #(
   .NUM_PORTS    (NUM_PORTS),
   .PINS_PER_PORT(PINS_PER_PORT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_en      (bus_en),
   .bus_we      (bus_we),
   .pin_out     (pin_out),
   .pin_oe      (pin_oe),
   .pin_pullup  (pin_pullup),
   .irq         (irq),
   .clk_req     (clk_req),
   .mode_flat   (mode_flat),
   .dout_flat   (dout_flat),
   .pulldis_flat(pulldis_flat),
   .evt_flat    (evt_flat)
);

// File: tb/tb_gpio_multiport_ctrl.sv
module tb_gpio_multiport_ctrl;

   localparam int NP   = 3;
   localparam int PP   = 8;
   localparam int NPIN = NP * PP;
   localparam int AW   = 9;

   localparam int O_IN = 4, O_DOUT = 8, O_MODE = 12, O_PULL = 16;
   localparam int O_EVT = 20, O_IEN = 24, O_FORCE = 28, O_EDGE = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            bus_en, bus_we;
   logic [AW-1:0]   bus_addr;
   logic [31:0]     bus_wdata, bus_rdata;
   logic [NPIN-1:0] pin_in, pin_out, pin_oe, pin_pullup;
   logic [NP-1:0]   irq;
   logic            clk_req, sync_sel;

   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   gpio_multiport_ctrl #(
      .NUM_PORTS(NP), .PINS_PER_PORT(PP), .SYNC_STAGES(2),
      .ADDR_W(AW), .VERSION_ID(7'd5)
   ) dut (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .pin_pullup(pin_pullup), .irq(irq), .clk_req(clk_req), .sync_sel(sync_sel)
   );

   function automatic int adr(input int port, input int off);
      return port * 48 + off;
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input int addr, input logic [31:0] d);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = AW'(addr); bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic chk_reg(input string req, input string what, input int addr,
                          input logic [31:0] exp);
      logic [31:0] d;
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = AW'(addr);
      #1;
      d = bus_rdata;
      bus_en = 1'b0;
      check(req, what, d, exp);
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset_state;
      for (int p = 0; p < NP; p++) begin
         chk_reg("R2", "mode", adr(p, O_MODE), 32'h0);
         chk_reg("R2", "dout", adr(p, O_DOUT), 32'h0);
         chk_reg("R2", "pull", adr(p, O_PULL), 32'h0);
         chk_reg("R2", "ien",  adr(p, O_IEN), 32'h0);
         chk_reg("R2", "evt",  adr(p, O_EVT), 32'h0);
         chk_reg("R2", "force", adr(p, O_FORCE), 32'h0);
         chk_reg("R2", "edge", adr(p, O_EDGE), 32'h0);
      end
      check("R2", "irq", 32'(irq), 32'h0);
      check("R2", "pin_oe", 32'(pin_oe), 32'h0);
      check("R2", "pin_pullup", 32'(pin_pullup), 32'h00FF_FFFF);
      check("R2", "clk_req", 32'(clk_req), 32'h0);
   endtask

   task automatic t_global_ctrl;
      chk_reg("R11", "ctrl reset", 0, 32'h0000_0614);
      wr(0, 32'h3);
      chk_reg("R11", "ctrl set", 0, 32'h0000_0617);
      check("R11", "clk_req on", 32'(clk_req), 32'h1);
      check("R11", "sync_sel on", 32'(sync_sel), 32'h1);
      wr(0, 32'hFFFF_FFFF);
      chk_reg("R11", "ro fields", 0, 32'h0000_0617);
      wr(0, 32'h0);
      chk_reg("R11", "ctrl off", 0, 32'h0000_0614);
      check("R11", "clk_req off", 32'(clk_req), 32'h0);
      check("R11", "sync_sel off", 32'(sync_sel), 32'h0);
   endtask

   task automatic t_address_map;
      wr(adr(2, O_DOUT), 32'hA5);
      chk_reg("R1", "port2 dout", adr(2, O_DOUT), 32'hA5);
      chk_reg("R1", "port0 dout", adr(0, O_DOUT), 32'h0);
      chk_reg("R1", "port1 dout", adr(1, O_DOUT), 32'h0);
      wr(adr(1, 36), 32'hFF);
      chk_reg("R1", "unmapped offset", adr(1, 36), 32'h0);
      wr(adr(3, O_DOUT), 32'hFF);
      chk_reg("R1", "past last port", adr(3, O_DOUT), 32'h0);
      chk_reg("R1", "port2 kept", adr(2, O_DOUT), 32'hA5);
      wr(adr(2, O_IN), 32'hFF);
      chk_reg("R1", "input ro", adr(2, O_IN), 32'h0);
      wr(adr(2, O_DOUT), 32'h0);
   endtask

   task automatic t_drive_modes;
      wr(adr(1, O_MODE), 32'h0039);
      wr(adr(1, O_DOUT), 32'h05);
      chk_reg("R3", "mode readback", adr(1, O_MODE), 32'h39);
      check("R3", "oe 11:8 dout=5", 32'(pin_oe[11:8]), 32'h7);
      check("R3", "out 10:8 dout=5", 32'(pin_out[10:8]), 32'h5);
      wr(adr(1, O_DOUT), 32'h02);
      check("R3", "oe 11:8 dout=2", 32'(pin_oe[11:8]), 32'h1);
      check("R3", "pushpull low", 32'(pin_out[8]), 32'h0);
      wr(adr(1, O_MODE), 32'h4000);
      check("R3", "pin7 field", 32'(pin_oe[15:8]), 32'h80);
      wr(adr(1, O_MODE), 32'h0);
      wr(adr(1, O_DOUT), 32'h0);
      check("R3", "inputs undriven", 32'(pin_oe), 32'h0);
   endtask

   task automatic t_pullup;
      wr(adr(2, O_PULL), 32'h0F);
      chk_reg("R4", "pull readback", adr(2, O_PULL), 32'h0F);
      check("R4", "pullup 23:16", 32'(pin_pullup[23:16]), 32'hF0);
      check("R4", "pullup others", 32'(pin_pullup[15:0]), 32'hFFFF);
      wr(adr(2, O_PULL), 32'h0);
      check("R4", "pullup restored", 32'(pin_pullup), 32'h00FF_FFFF);
   endtask

   task automatic t_input_sync;
      pin_in[3] = 1'b1;
      chk_reg("R5", "level edge0", adr(0, O_IN), 32'h0);
      step(1);
      chk_reg("R5", "level edge1", adr(0, O_IN), 32'h0);
      step(1);
      chk_reg("R5", "level edge2", adr(0, O_IN), 32'h08);
      pin_in[3] = 1'b0;
      step(3);
      chk_reg("R5", "level low", adr(0, O_IN), 32'h0);
      wr(adr(0, O_EVT), 32'hFF);
   endtask

   task automatic t_edge_select;
      wr(adr(1, O_EDGE), 32'h04);
      pin_in[10] = 1'b1;
      step(3);
      chk_reg("R6", "rising sel, rise", adr(1, O_EVT), 32'h04);
      wr(adr(1, O_EVT), 32'h04);
      pin_in[10] = 1'b0;
      step(3);
      chk_reg("R6", "rising sel, fall", adr(1, O_EVT), 32'h0);
      wr(adr(1, O_EDGE), 32'h0);
      pin_in[10] = 1'b1;
      step(3);
      chk_reg("R6", "falling sel, rise", adr(1, O_EVT), 32'h0);
      pin_in[10] = 1'b0;
      step(3);
      chk_reg("R6", "falling sel, fall", adr(1, O_EVT), 32'h04);
      wr(adr(1, O_EVT), 32'hFF);
   endtask

   task automatic t_irq_gating;
      pin_in[16] = 1'b1;
      step(3);
      pin_in[16] = 1'b0;
      step(3);
      chk_reg("R7", "flag without enable", adr(2, O_EVT), 32'h01);
      check("R7", "irq masked", 32'(irq), 32'h0);
      wr(adr(2, O_IEN), 32'h01);
      check("R7", "irq enabled", 32'(irq), 32'h4);
      wr(adr(2, O_IEN), 32'h0);
      check("R7", "irq disabled", 32'(irq), 32'h0);
      wr(adr(2, O_IEN), 32'h01);
      wr(adr(2, O_EVT), 32'h01);
      check("R7", "irq after clear", 32'(irq), 32'h0);
      pin_in[16] = 1'b1;
      step(3);
      pin_in[16] = 1'b0;
      step(2);
      check("R7", "irq at edge2", 32'(irq), 32'h0);
      step(1);
      check("R7", "irq at edge3", 32'(irq), 32'h4);
      wr(adr(2, O_EVT), 32'h01);
      wr(adr(2, O_IEN), 32'h0);
   endtask

   task automatic t_w1c;
      pin_in[1:0] = 2'b11;
      step(3);
      pin_in[1:0] = 2'b00;
      step(3);
      chk_reg("R8", "two flags", adr(0, O_EVT), 32'h03);
      wr(adr(0, O_EVT), 32'h02);
      chk_reg("R8", "clear one", adr(0, O_EVT), 32'h01);
      wr(adr(0, O_EVT), 32'h00);
      chk_reg("R8", "write zero", adr(0, O_EVT), 32'h01);
      wr(adr(0, O_EVT), 32'h01);
      chk_reg("R8", "clear last", adr(0, O_EVT), 32'h0);
   endtask

   task automatic t_edge_beats_clear;
      pin_in[5] = 1'b1;
      step(3);
      chk_reg("R9", "no flag on rise", adr(0, O_EVT), 32'h0);
      pin_in[5] = 1'b0;
      step(2);
      wr(adr(0, O_EVT), 32'h20);
      chk_reg("R9", "edge wins", adr(0, O_EVT), 32'h20);
      wr(adr(0, O_EVT), 32'h20);
      chk_reg("R9", "later clear", adr(0, O_EVT), 32'h0);
   endtask

   task automatic t_force;
      wr(adr(1, O_FORCE), 32'h81);
      step(1);
      chk_reg("R10", "forced flags", adr(1, O_EVT), 32'h81);
      wr(adr(1, O_EVT), 32'h81);
      chk_reg("R10", "clear while forced", adr(1, O_EVT), 32'h81);
      wr(adr(1, O_FORCE), 32'h0);
      wr(adr(1, O_EVT), 32'hFF);
      chk_reg("R10", "clear after release", adr(1, O_EVT), 32'h0);
      chk_reg("R10", "force off", adr(1, O_FORCE), 32'h0);
   endtask

   initial begin
      bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
      step(3);
      rst_n = 1'b1;
      step(1);
      t_reset_state();
      t_global_ctrl();
      t_address_map();
      t_drive_modes();
      t_pullup();
      t_input_sync();
      t_edge_select();
      t_irq_gating();
      t_w1c();
      t_edge_beats_clear();
      t_force();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule